// File: doc/BRIEF.md
# Privilege-Gated Cycle Counter Unit

This block keeps a free-running count of clock cycles since reset and answers requests to read it. Two request kinds exist. An ordinary stamp read is checked against the current processor mode, the current privilege level and a stamp-lock control bit. A privileged register read is checked against the privilege level alone.

Each request receives a registered answer one cycle later. A granted request returns the count as two halves, each of width `HALF_W`. A refused request raises a general-protection fault strobe together with an error code of zero.

Instruction decode, ordering against other instructions, fault delivery and writes to the counter all sit outside this block. Reads leave every status flag untouched.

Top module: `cyc_stamp_unit`

## Requirements
- R1: The counter is `2*HALF_W` bits wide, is cleared to zero asynchronously while `rst_n` is low, and adds one on every rising clock edge while `rst_n` is high.
- R2: A granted request raises `rsp_data_vld` for exactly one cycle, in the cycle after the request. `rsp_hi` then carries the upper half and `rsp_lo` the lower half of the count held during the request cycle.
- R3: The mode is encoded as real=0, protected=1, virtual-8086=2, with code 3 handled like real. With `stamp_lock` low, an ordinary read is granted in every mode at every privilege level from 0 to 3.
- R4: With `stamp_lock` high in protected mode (1), an ordinary read is granted at privilege level 0 and refused at levels 1, 2 and 3.
- R5: With `stamp_lock` high in real (0), virtual-8086 (2) or code-3 mode, an ordinary read is refused at every privilege level.
- R6: A privileged register read is granted when `priv_lvl` is 0 and refused otherwise, whatever the mode and the lock bit.
- R7: A refused request raises `rsp_fault_vld` for one cycle, in the cycle after the request, with `rsp_fault_code` all zeros. In that cycle `rsp_data_vld` is low and both halves read zero.
- R8: `rsp_data_vld` and `rsp_fault_vld` are never high together. In a cycle that follows no request, both are low and both halves read zero.
- R9: When both request kinds arrive in the same cycle, the privileged register-read rule (R6) decides the answer.
- R10: The counter passes from all ones to zero with no fault and no other indication, and reads on either side of the wrap return consecutive values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| rd_req | input | 1 | Ordinary stamp-read request |
| reg_rd_req | input | 1 | Privileged register-read request |
| cpu_mode | input | 2 | Processor mode: 0 real, 1 protected, 2 virtual-8086 |
| priv_lvl | input | 2 | Current privilege level, 0 is most privileged |
| stamp_lock | input | 1 | When high, restricts ordinary reads |
| rsp_data_vld | output | 1 | Granted-read strobe |
| rsp_hi | output | HALF_W | Upper half of the sampled count |
| rsp_lo | output | HALF_W | Lower half of the sampled count |
| rsp_fault_vld | output | 1 | General-protection fault strobe |
| rsp_fault_code | output | FC_W | Fault error code, always zero |

## Verification
The assertions watch every cycle for the following:
- the counter stepping by exactly one, wrap included;
- the two response strobes staying mutually exclusive;
- granted data equalling the count of the previous cycle;
- zeroed halves on idle and fault cycles;
- the fault code staying zero;
- the grant or refusal following each locked-protected, virtual-8086 and privileged-read request.

The absolute count after each reset is visible only in the bench's scenarios. So are the full mode, privilege and lock matrix, the precedence of simultaneous requests, and the wrap. The wrap is observed on a narrow second instance.

// File: rtl/cyc_stamp_pkg.sv
package cyc_stamp_pkg;

  typedef enum logic [1:0] {
    CM_REAL = 2'd0,
    CM_PROT = 2'd1,
    CM_V86  = 2'd2,
    CM_RSVD = 2'd3
  } cpu_mode_e;

  localparam int          PL_W      = 2;
  localparam logic [PL_W-1:0] PL_KERNEL = '0;

endpackage

// File: rtl/cyc_stamp_ctr.sv
module cyc_stamp_ctr #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_q
);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/cyc_stamp_gate.sv
module cyc_stamp_gate
  import cyc_stamp_pkg::*;
#(
  parameter int FC_W = 16
) (
  input  logic            rd_req,
  input  logic            reg_rd_req,
  input  cpu_mode_e       mode,
  input  logic [PL_W-1:0] pl,
  input  logic            lock,
  output logic            grant,
  output logic            refuse,
  output logic [FC_W-1:0] err_code
);

  logic kernel;
  logic norm_ok;

  always_comb begin
    kernel = (pl == PL_KERNEL);
    case (mode)
      CM_PROT: norm_ok = !lock || kernel;
      CM_V86:  norm_ok = !lock;
      CM_REAL: norm_ok = !lock;
      default: norm_ok = !lock;
    endcase
  end

  always_comb begin
    grant    = 1'b0;
    refuse   = 1'b0;
    err_code = '0;
    if (reg_rd_req) begin
      grant  = kernel;
      refuse = !kernel;
    end else if (rd_req) begin
      grant  = norm_ok;
      refuse = !norm_ok;
    end
  end

endmodule

// File: rtl/cyc_stamp_resp.sv
module cyc_stamp_resp #(
  parameter int HALF_W = 32,
  parameter int FC_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  grant,
  input  logic                  refuse,
  input  logic [FC_W-1:0]       err_code,
  input  logic [2*HALF_W-1:0]   cnt,
  output logic                  data_vld,
  output logic                  fault_vld,
  output logic [HALF_W-1:0]     hi,
  output logic [HALF_W-1:0]     lo,
  output logic [FC_W-1:0]       fcode
);

  localparam int WORD_W = 2 * HALF_W;

  logic              data_vld_q, fault_vld_q;
  logic              data_vld_d, fault_vld_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              word_en;
  logic [FC_W-1:0]   fcode_q, fcode_d;
  logic              fcode_en;

  always_comb begin
    data_vld_d  = grant;
    fault_vld_d = refuse && !grant;
    word_d      = grant ? cnt : '0;
    word_en     = grant || data_vld_q;
    fcode_d     = refuse ? err_code : '0;
    fcode_en    = refuse || fault_vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_vld_q  <= 1'b0;
      fault_vld_q <= 1'b0;
    end else begin
      data_vld_q  <= data_vld_d;
      fault_vld_q <= fault_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fcode_q <= '0;
    else if (fcode_en) fcode_q <= fcode_d;
  end

  assign data_vld  = data_vld_q;
  assign fault_vld = fault_vld_q;
  assign hi        = word_q[WORD_W-1:HALF_W];
  assign lo        = word_q[HALF_W-1:0];
  assign fcode     = fcode_q;

endmodule

// File: rtl/cyc_stamp_unit.sv
module cyc_stamp_unit
  import cyc_stamp_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int FC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              reg_rd_req,
  input  logic [1:0]        cpu_mode,
  input  logic [1:0]        priv_lvl,
  input  logic              stamp_lock,
  output logic              rsp_data_vld,
  output logic [HALF_W-1:0] rsp_hi,
  output logic [HALF_W-1:0] rsp_lo,
  output logic              rsp_fault_vld,
  output logic [FC_W-1:0]   rsp_fault_code
);

  localparam int CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0] cnt_q;
  logic             grant, refuse;
  logic [FC_W-1:0]  err_code;
  cpu_mode_e        mode_e;

  assign mode_e = cpu_mode_e'(cpu_mode);

  cyc_stamp_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt_q (cnt_q)
  );

  cyc_stamp_gate #(.FC_W(FC_W)) u_gate (
    .rd_req     (rd_req),
    .reg_rd_req (reg_rd_req),
    .mode       (mode_e),
    .pl         (priv_lvl),
    .lock       (stamp_lock),
    .grant      (grant),
    .refuse     (refuse),
    .err_code   (err_code)
  );

  cyc_stamp_resp #(.HALF_W(HALF_W), .FC_W(FC_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (grant),
    .refuse    (refuse),
    .err_code  (err_code),
    .cnt       (cnt_q),
    .data_vld  (rsp_data_vld),
    .fault_vld (rsp_fault_vld),
    .hi        (rsp_hi),
    .lo        (rsp_lo),
    .fcode     (rsp_fault_code)
  );

endmodule

// File: rtl/cyc_stamp_chk.sv
module cyc_stamp_chk #(
  parameter int HALF_W = 32,
  parameter int FC_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic              reg_rd_req,
  input logic [1:0]        cpu_mode,
  input logic [1:0]        priv_lvl,
  input logic              stamp_lock,
  input logic              rsp_data_vld,
  input logic [HALF_W-1:0] rsp_hi,
  input logic [HALF_W-1:0] rsp_lo,
  input logic              rsp_fault_vld,
  input logic [FC_W-1:0]   rsp_fault_code,
  input logic [2*HALF_W-1:0] cnt_q
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> cnt_q == $past(cnt_q) + 1'b1);                         // R1

  AST_DATA_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rsp_data_vld) |-> {rsp_hi, rsp_lo} == $past(cnt_q));   // R2

  AST_UNLOCK_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !reg_rd_req && !stamp_lock) |=> rsp_data_vld);         // R3

  AST_PROT_USER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !reg_rd_req && stamp_lock && cpu_mode == 2'd1 && priv_lvl != 2'd0)
      |=> rsp_fault_vld);                                              // R4

  AST_V86_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !reg_rd_req && stamp_lock && cpu_mode == 2'd2)
      |=> rsp_fault_vld);                                              // R5

  AST_REG_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_req && priv_lvl != 2'd0) |=> (rsp_fault_vld && !rsp_data_vld)); // R6

  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault_vld |-> (rsp_fault_code == '0 && rsp_hi == '0 && rsp_lo == '0)); // R7

  AST_RSP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_data_vld && rsp_fault_vld));                                 // R8

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_data_vld |-> (rsp_hi == '0 && rsp_lo == '0));                 // R8

endmodule

bind cyc_stamp_unit cyc_stamp_chk #(.HALF_W(HALF_W), .FC_W(FC_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rd_req         (rd_req),
  .reg_rd_req     (reg_rd_req),
  .cpu_mode       (cpu_mode),
  .priv_lvl       (priv_lvl),
  .stamp_lock     (stamp_lock),
  .rsp_data_vld   (rsp_data_vld),
  .rsp_hi         (rsp_hi),
  .rsp_lo         (rsp_lo),
  .rsp_fault_vld  (rsp_fault_vld),
  .rsp_fault_code (rsp_fault_code),
  .cnt_q          (cnt_q)
);

// File: tb/cyc_stamp_unit_test.sv
`timescale 1ns/1ps
module cyc_stamp_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req = 1'b0, reg_rd_req = 1'b0;
  logic [1:0]  mode = 2'd0, pl = 2'd0;
  logic        lock = 1'b0;

  logic        dv, fv, dv_s, fv_s;
  logic [31:0] hi, lo;
  logic [3:0]  hi_s, lo_s;
  logic [15:0] fc, fc_s;

  logic [63:0] edges;
  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) edges <= 64'd0;
    else        edges <= edges + 64'd1;
  end

  cyc_stamp_unit uut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .reg_rd_req(reg_rd_req),
    .cpu_mode(mode), .priv_lvl(pl), .stamp_lock(lock),
    .rsp_data_vld(dv), .rsp_hi(hi), .rsp_lo(lo),
    .rsp_fault_vld(fv), .rsp_fault_code(fc)
  );

  cyc_stamp_unit #(.HALF_W(4), .FC_W(16)) uut_small (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .reg_rd_req(reg_rd_req),
    .cpu_mode(mode), .priv_lvl(pl), .stamp_lock(lock),
    .rsp_data_vld(dv_s), .rsp_hi(hi_s), .rsp_lo(lo_s),
    .rsp_fault_vld(fv_s), .rsp_fault_code(fc_s)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_grant(input bit is_reg, input logic [1:0] m,
                                   input logic [1:0] p, input logic l);
    if (is_reg) return (p == 2'd0);
    if (!l)     return 1'b1;
    if (m == 2'd1) return (p == 2'd0);
    return 1'b0;
  endfunction

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic issue(input bit is_reg, input bit both, input logic [1:0] m,
                       input logic [1:0] p, input logic l);
    logic [63:0] exp_cnt;
    bit ok;
    string tag;
    rd_req = !is_reg || both;
    reg_rd_req = is_reg;
    mode = m; pl = p; lock = l;
    exp_cnt = edges;
    ok = exp_grant(is_reg, m, p, l);
    if (is_reg)      tag = both ? "R9" : "R6";
    else if (!l)     tag = "R3";
    else if (m == 2'd1) tag = "R4";
    else             tag = "R5";
    @(negedge clk);
    rd_req = 1'b0;
    reg_rd_req = 1'b0;
    check(tag, {63'd0, dv}, {63'd0, ok});
    check(tag, {63'd0, fv}, {63'd0, !ok});
    check("R2", {32'd0, hi}, ok ? {32'd0, exp_cnt[63:32]} : 64'd0);
    check("R2", {32'd0, lo}, ok ? {32'd0, exp_cnt[31:0]} : 64'd0);
    check("R7", {48'd0, fc}, 64'd0);
    check("R10", {56'd0, hi_s, lo_s}, ok ? {56'd0, exp_cnt[7:0]} : 64'd0);
    check("R10", {62'd0, dv_s, fv_s}, {62'd0, ok, !ok});
  endtask

  task automatic idle_check;
    @(negedge clk);
    check("R8", {62'd0, dv, fv}, 64'd0);
    check("R8", {hi, lo}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", {62'd0, dv, fv}, 64'd0);
    check("R1", {hi, lo}, 64'd0);
    rst_n = 1'b1;
    // first read right after release returns zero
    issue(1'b0, 1'b0, 2'd0, 2'd3, 1'b0);
    idle_check();
    // exhaustive mode / privilege / lock matrix for both kinds
    for (int k = 0; k < 2; k++)
      for (int l = 0; l < 2; l++)
        for (int m = 0; m < 4; m++)
          for (int p = 0; p < 4; p++)
            issue(k[0], 1'b0, m[1:0], p[1:0], l[0]);
    // simultaneous requests: privileged rule decides
    issue(1'b1, 1'b1, 2'd1, 2'd3, 1'b0);
    issue(1'b1, 1'b1, 2'd2, 2'd0, 1'b1);
    issue(1'b1, 1'b1, 2'd0, 2'd2, 1'b0);
    idle_check();
    // mid-run asynchronous reset
    #1 rst_n = 1'b0;
    @(negedge clk);
    check("R1", {62'd0, dv, fv}, 64'd0);
    check("R1", {hi, lo}, 64'd0);
    rst_n = 1'b1;
    issue(1'b0, 1'b0, 2'd1, 2'd0, 1'b1);
    // wrap on the narrow instance
    while (edges[7:0] != 8'hFE) @(negedge clk);
    issue(1'b0, 1'b0, 2'd0, 2'd1, 1'b0);
    issue(1'b0, 1'b0, 2'd0, 2'd1, 1'b0);
    issue(1'b0, 1'b0, 2'd0, 2'd1, 1'b0);
    issue(1'b1, 1'b0, 2'd2, 2'd0, 1'b1);
    // constrained random
    for (int i = 0; i < 400; i++) begin
      int kind;
      kind = $urandom % 4;
      issue(kind == 2 || kind == 3, kind == 3, 2'($urandom % 4),
            2'($urandom % 4), 1'($urandom % 2));
      if ($urandom % 5 == 0) idle_check();
    end
    idle_check();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule